// File: doc/BRIEF.md
# Instruction Fetch Address Sequencer

This block owns the instruction fetch address of a small two-stage fetch/execute core. Each instruction cycle, marked by a one-cycle `tick` pulse, the instruction at the current fetch address is fetched while the instruction fetched one cycle earlier executes. The executing instruction tells the sequencer what to do through a set of strobes. It can step to the next word or jump to a full-width target. It can call a subroutine, return from one, or overwrite the low byte of the counter.

Every change of flow costs one extra cycle. The word already fetched next to the branching instruction is discarded, and the block reports this on `flush_o` so that decode executes that slot as a no-op. Return addresses live in a small hardware stack with no error reporting. A call past its depth silently drops the oldest entry. A return past its depth keeps handing back the deepest entry, because each pop copies that entry upward.

The control is a two-state machine. `ST_EXEC` is the normal state. In it, a tick carrying a change of flow moves the machine to `ST_FLUSH`, and any other tick, or the absence of a tick, keeps it in `ST_EXEC`. In `ST_FLUSH` all strobes are ignored. The next tick advances the counter by one and returns the machine to `ST_EXEC`. Without a tick the machine stays in `ST_FLUSH`.

Top module: `fetch_addr_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `fetch_addr_o` is all ones (1FFh with `ADDR_W`=9) and `flush_o` is 0.
- R2: In `ST_EXEC`, a tick with `seq_i` high and no branch strobe raises the fetch address by one, modulo 2^`ADDR_W`, so 1FFh steps to 000h.
- R3: Without a tick, the fetch address and `flush_o` keep their values whatever the strobes do. A tick in `ST_EXEC` with no strobe at all also leaves the address unchanged.
- R4: A jump tick loads all `ADDR_W` bits of `target_i` into the fetch address.
- R5: A call tick loads `target_i[ADDR_W-2:0]` into the low bits and forces the top bit to 0. It pushes the fetch address current in that cycle, which is the word after the call, as the return address.
- R6: A low-write tick loads `low_data_i` into the low bits and forces the top bit to 0.
- R7: A return tick loads the newest stack entry into the fetch address and pops the stack, with each level taking the value of the level below it.
- R8: The stack holds `DEPTH` entries, which reset to 0. A push beyond `DEPTH` discards the oldest entry. On a pop the deepest entry keeps its value, so returns past the depth keep giving that address.
- R9: After every jump, call, return or low-write tick, `flush_o` is high from the next cycle until the next tick. During that time the strobes are ignored, and that tick advances the address by one and clears `flush_o`.
- R10: When several strobes are high on one tick in `ST_EXEC`, only one takes effect. Jump wins over call, call over return, return over low-write, and low-write over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per instruction cycle |
| seq_i | input | 1 | Step to the next word |
| jump_i | input | 1 | Jump to the full target |
| call_i | input | 1 | Call the target in the lower page |
| ret_i | input | 1 | Return through the stack |
| low_wr_i | input | 1 | Write the counter low byte from the data path |
| target_i | input | ADDR_W | Target field of the instruction word |
| low_data_i | input | ADDR_W-1 | Data-path value for a low-byte write |
| fetch_addr_o | output | ADDR_W | Current fetch address |
| flush_o | output | 1 | Instruction now executing is turned into a no-op |

## Verification
The bench builds the block with its defaults, `ADDR_W`=9 and `DEPTH`=2. A stack of two is overrun by the third nested call and underrun by the third return, so both the silent drop of the oldest entry and the repeated deepest entry are checked. The 9-bit counter starts at its last word, so the very first step checks the wrap to 000h. A later run of 600 steps wraps the counter a second time.

// File: rtl/fau_pkg.sv
package fau_pkg;
    typedef enum logic {
        ST_EXEC  = 1'b0,
        ST_FLUSH = 1'b1
    } fau_state_e;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_JUMP  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_LOWWR = 3'd5
    } fau_op_e;
endpackage

// File: rtl/fau_ctrl.sv
module fau_ctrl
    import fau_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    seq_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    low_wr_i,
    output fau_op_e op_o,
    output logic    flush_o
);
    fau_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EXEC;
        else        state_q <= state_d;
    end

    // next-state and operation select
    always_comb begin
        state_d = state_q;
        op_o    = OP_HOLD;
        unique case (state_q)
            ST_EXEC: begin
                if (tick) begin
                    // priority: jump, call, return, low write, step
                    if (jump_i)        op_o = OP_JUMP;
                    else if (call_i)   op_o = OP_CALL;
                    else if (ret_i)    op_o = OP_RET;
                    else if (low_wr_i) op_o = OP_LOWWR;
                    else if (seq_i)    op_o = OP_STEP;
                    if (jump_i || call_i || ret_i || low_wr_i)
                        state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (tick) begin
                    op_o    = OP_STEP;
                    state_d = ST_EXEC;
                end
            end
            default: state_d = ST_EXEC;
        endcase
    end

    assign flush_o = (state_q == ST_FLUSH);
endmodule

// File: rtl/fau_stack.sv
module fau_stack #(
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] top_val
);
    logic [ADDR_W-1:0] lvl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [ADDR_W-1:0] q;
        logic [ADDR_W-1:0] from_above;
        logic [ADDR_W-1:0] from_below;

        if (i == 0) begin : g_top
            assign from_above = push_val;
        end else begin : g_mid
            assign from_above = lvl[i-1];
        end

        if (i == DEPTH - 1) begin : g_deep
            assign from_below = q;      // deepest entry is duplicated on pop
        end else begin : g_shallow
            assign from_below = lvl[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (push) q <= from_above;
            else if (pop)  q <= from_below;
        end

        assign lvl[i] = q;
    end

    assign top_val = lvl[0];
endmodule

// File: rtl/fau_counter.sv
module fau_counter
    import fau_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fau_op_e           op,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-2:0] low_data,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] pc
);
    localparam int LOW_W = ADDR_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '1;
        end else begin
            unique case (op)
                OP_HOLD:  pc <= pc;
                OP_STEP:  pc <= pc + 1'b1;
                OP_JUMP:  pc <= target;
                OP_CALL:  pc <= {1'b0, target[LOW_W-1:0]};
                OP_RET:   pc <= stack_top;
                OP_LOWWR: pc <= {1'b0, low_data};
                default:  pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
    import fau_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              seq_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              low_wr_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-2:0] low_data_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              flush_o
);
    fau_op_e           op;
    logic [ADDR_W-1:0] stack_top;
    logic [ADDR_W-1:0] pc;

    fau_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .seq_i    (seq_i),
        .jump_i   (jump_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .low_wr_i (low_wr_i),
        .op_o     (op),
        .flush_o  (flush_o)
    );

    fau_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (op == OP_CALL),
        .pop      (op == OP_RET),
        .push_val (pc),
        .top_val  (stack_top)
    );

    fau_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .target    (target_i),
        .low_data  (low_data_i),
        .stack_top (stack_top),
        .pc        (pc)
    );

    assign fetch_addr_o = pc;
endmodule

// File: rtl/fau_checker.sv
module fau_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              seq_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              low_wr_i,
    input logic [ADDR_W-1:0] target_i,
    input logic [ADDR_W-2:0] low_data_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              flush_o
);
    logic any_branch;
    assign any_branch = jump_i | call_i | ret_i | low_wr_i;

    assert_reset_vector_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (fetch_addr_o == {ADDR_W{1'b1}}) && !flush_o);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flush_o && seq_i && !any_branch)
        |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(fetch_addr_o) && $stable(flush_o));

    assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flush_o && jump_i) |=> fetch_addr_o == $past(target_i));

    assert_call_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flush_o && call_i && !jump_i) |=> !fetch_addr_o[ADDR_W-1]);

    assert_lowwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flush_o && low_wr_i && !jump_i && !call_i && !ret_i)
        |=> fetch_addr_o == {1'b0, $past(low_data_i)});

    assert_branch_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !flush_o && any_branch) |=> flush_o);

    assert_flush_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && flush_o)
        |=> !flush_o && fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));
endmodule

bind fetch_addr_unit fau_checker #(.ADDR_W(ADDR_W)) u_fau_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .seq_i        (seq_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .low_wr_i     (low_wr_i),
    .target_i     (target_i),
    .low_data_i   (low_data_i),
    .fetch_addr_o (fetch_addr_o),
    .flush_o      (flush_o)
);

// File: tb/sim_fetch_addr_unit.sv
module sim_fetch_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, seq_i = 1'b0, jump_i = 1'b0, call_i = 1'b0;
    logic          ret_i = 1'b0, low_wr_i = 1'b0;
    logic [AW-1:0] target_i = '0;
    logic [AW-2:0] low_data_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic          flush_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] pc;
        logic          fl;
        string         tag;
    } exp_t;
    exp_t sb[$];

    // reference state derived from the requirements
    logic [AW-1:0] m_pc = '1;
    logic [AW-1:0] m_s0 = '0, m_s1 = '0;
    logic          m_fl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_addr_unit #(.ADDR_W(AW), .DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .seq_i(seq_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .low_wr_i(low_wr_i), .target_i(target_i),
        .low_data_i(low_data_i), .fetch_addr_o(fetch_addr_o), .flush_o(flush_o)
    );

    task automatic compare(input logic [AW-1:0] pc, input logic fl, input string tag);
        checks++;
        if (fetch_addr_o !== pc || flush_o !== fl) begin
            errors++;
            $display("FAIL %s: addr=%h flush=%b expected addr=%h flush=%b",
                     tag, fetch_addr_o, flush_o, pc, fl);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outcome
    task automatic step(input logic tk, sq, jp, cl, rt, pw,
                        input logic [AW-1:0] tgt, input logic [AW-2:0] dat,
                        input string tag);
        exp_t e;
        @(negedge clk);
        tick = tk; seq_i = sq; jump_i = jp; call_i = cl; ret_i = rt; low_wr_i = pw;
        target_i = tgt; low_data_i = dat;
        if (tk) begin
            if (m_fl) begin
                m_pc = m_pc + 1'b1; m_fl = 1'b0;
            end else if (jp) begin
                m_pc = tgt; m_fl = 1'b1;
            end else if (cl) begin
                m_s1 = m_s0; m_s0 = m_pc; m_pc = {1'b0, tgt[AW-2:0]}; m_fl = 1'b1;
            end else if (rt) begin
                m_pc = m_s0; m_s0 = m_s1; m_fl = 1'b1;
            end else if (pw) begin
                m_pc = {1'b0, dat}; m_fl = 1'b1;
            end else if (sq) begin
                m_pc = m_pc + 1'b1;
            end
        end
        e.pc = m_pc; e.fl = m_fl; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares a quarter period after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.pc, e.fl, e.tag);
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(9'h1FF, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #(CLK_PERIOD/4);
        compare(9'h1FF, 1'b0, "R1 after release");

        step(1,1,0,0,0,0, 9'h000, 8'h00, "R2 wrap 1FF to 000");
        step(0,1,1,1,1,1, 9'h0AA, 8'h55, "R3 no tick hold");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R3 tick without strobe");
        step(1,1,0,0,0,0, 9'h000, 8'h00, "R2 step");
        step(1,0,1,0,0,0, 9'h1F0, 8'h00, "R4 jump");
        step(1,0,0,1,0,0, 9'h055, 8'h00, "R9 strobes ignored in flush");
        step(1,1,0,0,0,0, 9'h000, 8'h00, "R2 step after flush");
        step(1,0,0,1,0,0, 9'h1AB, 8'h00, "R5 call forces top bit 0");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,1,0,0, 9'h033, 8'h00, "R8 second call");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,1,0,0, 9'h077, 8'h00, "R8 third call drops oldest");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,0,1,0, 9'h000, 8'h00, "R7 return newest");
        step(1,1,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,0,1,0, 9'h000, 8'h00, "R7 return second");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,0,1,0, 9'h000, 8'h00, "R8 underflow repeats deepest");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,0,0,1, 9'h000, 8'hC3, "R6 low write");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,1,1,0,0, 9'h150, 8'h00, "R10 jump over call");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,1,1,1, 9'h122, 8'h44, "R10 call over return");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,0,0,0,1,1, 9'h000, 8'h66, "R10 return over low write");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush step");
        step(1,1,0,0,0,1, 9'h000, 8'h10, "R10 low write over step");
        step(0,0,0,0,0,0, 9'h000, 8'h00, "R9 flush held without tick");
        step(1,0,0,0,0,0, 9'h000, 8'h00, "R9 flush released by tick");
        for (int i = 0; i < 600; i++)
            step(1,1,0,0,0,0, 9'h000, 8'h00, "R2 long run wrap");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule